// File: doc/BRIEF.md
# ATM Cell Header Processor

This block sits on one input link of a cell switch. It takes 53-byte cells as a byte stream, with a start strobe on the first byte. It splits the five header bytes into field registers. It uses the low bits of the connection identifier to read a per-link routing table, and then hands a 48-bit word to the switching core in a single cycle. That word is the four-byte header prefix, the header check byte and the first payload byte. Alongside the word it gives the translated path identifier, the translated channel identifier, the output link number and a discard flag.

The header layout is taken most significant bit first: flow-control nibble, 8-bit path identifier, 16-bit channel identifier, 3-bit payload type, loss-priority bit and 8-bit check byte. The table read is issued in the same cycle that the fourth header byte is accepted. The 47 remaining payload bytes go into a shallow FIFO. They are released only a fixed number of cycles after the header word, which gives the core that time to decide whether the cell passes or is rejected.

A separate write port loads table entries. Every entry resets to invalid.

Top module: `atm_hdr_proc`

## Requirements
- R1: When `hdr_valid` is high, `hdr_vpi`, `hdr_vci`, `hdr_pt`, `hdr_clp` and `hdr_hec` hold the header fields. The fields are read from the first five bytes, most significant bit first, in this order: 4-bit GFC, 8-bit VPI, 16-bit VCI, 3-bit PT, 1-bit CLP, 8-bit HEC.
- R2: `hdr_valid` pulses for exactly one cycle per cell, in the cycle after the sixth cell byte (byte index 5) is accepted. In that cycle, `hdr_word[47:8]` holds the five header bytes with byte 0 in the top bits, and `hdr_word[7:0]` holds byte 5.
- R3: The table index is VCI[7:0]. When `hdr_valid` is high, `rt_vpi`, `rt_vci` and `rt_link` carry the stored entry for that index.
- R4: After reset every entry is invalid. A cell whose entry is invalid leaves with `rt_drop` = 1, and a cell whose entry is valid leaves with `rt_drop` = 0.
- R5: The table is read at the clock edge that accepts byte index 3. A configuration write to the same index at that same edge does not reach the current cell, which gets the old entry. The next cell sees the new entry.
- R6: Bytes 6 to 52 appear on `pay_data` in order, one per `pay_valid` cycle, with none lost. `pay_last` marks byte 52. With an unbroken input stream, the first of these bytes appears exactly HOLD_CYC (default 6) cycles after `hdr_valid`.
- R7: A byte with `in_valid` = 1 and `in_sop` = 0 while no cell is in progress is ignored. When `in_valid` = 0, the cell pauses without losing its place.
- R8: If `in_sop` arrives on an accepted byte while a cell is in progress, `cell_err` pulses in the next cycle. The byte starts a new cell, and any payload still held from the cut cell is discarded.
- R9: During and straight after reset, `hdr_valid`, `pay_valid` and `cell_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is the first of a cell |
| in_data | input | 8 | Input byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | IDX_W | Table entry index to write |
| cfg_ok | input | 1 | Written entry is valid |
| cfg_link | input | 2 | Output link for the entry |
| cfg_vpi | input | 8 | Outgoing path identifier for the entry |
| cfg_vci | input | 16 | Outgoing channel identifier for the entry |
| hdr_valid | output | 1 | Header word and route result valid |
| hdr_word | output | 48 | Header bytes plus first payload byte |
| hdr_vpi | output | 8 | Incoming path identifier |
| hdr_vci | output | 16 | Incoming channel identifier |
| hdr_pt | output | 3 | Payload type |
| hdr_clp | output | 1 | Loss-priority bit |
| hdr_hec | output | 8 | Header check byte |
| rt_vpi | output | 8 | Translated path identifier |
| rt_vci | output | 16 | Translated channel identifier |
| rt_link | output | 2 | Output link number |
| rt_drop | output | 1 | Entry invalid, discard cell |
| pay_valid | output | 1 | Payload byte present |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Last byte of the cell |
| cell_err | output | 1 | Cell cut short by a new start |

## Verification
The table lookup and a configuration write can land on the same clock edge for the same entry. The bench provokes this by raising the write strobe for the cell's own index exactly as byte index 3 is presented. It judges the result by requiring the old route on that cell and the new route on the following cell to the same index. A second collision comes from a start strobe arriving while the previous cell's payload is still draining from the FIFO. Here the bench checks the error pulse and requires that the new cell's payload stream is complete and uncorrupted.

// File: rtl/atm_hp_pkg.sv
package atm_hp_pkg;
    localparam int BYTE_W     = 8;
    localparam int VPI_W      = 8;
    localparam int VCI_W      = 16;
    localparam int LINK_W     = 2;
    localparam int HDR_BYTES  = 5;
    localparam int CELL_BYTES = 53;
    localparam int HDR_BITS   = HDR_BYTES * BYTE_W;
    localparam int WORD_W     = HDR_BITS + BYTE_W;
    localparam int CNT_W      = $clog2(CELL_BYTES);

    typedef struct packed {
        logic              ok;
        logic [LINK_W-1:0] link;
        logic [VPI_W-1:0]  vpi;
        logic [VCI_W-1:0]  vci;
    } route_t;
endpackage

// File: rtl/atm_hp_route_table.sv
module atm_hp_route_table
    import atm_hp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output route_t           rd_entry,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  route_t           wr_entry
);
    localparam int DEPTH = 1 << IDX_W;

    route_t             mem [DEPTH];
    logic [DEPTH-1:0]   ok_q;
    route_t             rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q <= '0;
        end else if (we) begin
            ok_q[wr_idx] <= wr_entry.ok;
        end
    end

    // Read samples storage before this edge's write lands: old data wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q    <= mem[rd_idx];
            rd_q.ok <= ok_q[rd_idx];
        end
    end

    assign rd_entry = rd_q;

    assert_wr_idx_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(wr_idx));
endmodule

// File: rtl/atm_hp_fifo.sv
module atm_hp_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } fst_t;

    fst_t             f_q, f_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_push, do_pop;

    assign empty   = (f_q.cnt == '0);
    assign full    = (f_q.cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[f_q.rd];

    always_comb begin
        f_d = f_q;
        if (flush) begin
            f_d = '0;
        end else begin
            if (do_push) begin
                f_d.wr = (f_q.wr == AW'(DEPTH-1)) ? '0 : f_q.wr + 1'b1;
            end
            if (do_pop) begin
                f_d.rd = (f_q.rd == AW'(DEPTH-1)) ? '0 : f_q.rd + 1'b1;
            end
            f_d.cnt = f_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[f_q.wr] <= din;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/atm_hdr_proc.sv
module atm_hdr_proc
    import atm_hp_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int HOLD_CYC   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic [BYTE_W-1:0]     in_data,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_addr,
    input  logic                  cfg_ok,
    input  logic [LINK_W-1:0]     cfg_link,
    input  logic [VPI_W-1:0]      cfg_vpi,
    input  logic [VCI_W-1:0]      cfg_vci,
    output logic                  hdr_valid,
    output logic [WORD_W-1:0]     hdr_word,
    output logic [VPI_W-1:0]      hdr_vpi,
    output logic [VCI_W-1:0]      hdr_vci,
    output logic [2:0]            hdr_pt,
    output logic                  hdr_clp,
    output logic [7:0]            hdr_hec,
    output logic [VPI_W-1:0]      rt_vpi,
    output logic [VCI_W-1:0]      rt_vci,
    output logic [LINK_W-1:0]     rt_link,
    output logic                  rt_drop,
    output logic                  pay_valid,
    output logic [BYTE_W-1:0]     pay_data,
    output logic                  pay_last,
    output logic                  cell_err
);
    localparam int HOLD_W  = $clog2(HOLD_CYC + 1);
    localparam int LOOK_AT = 3;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [HDR_BITS-1:0] hdr;
        logic                hv;
        logic [WORD_W-1:0]   word;
        route_t              rt;
        logic [HOLD_W-1:0]   hold;
        logic                rel;
        logic                err;
    } st_t;

    st_t               s_q, s_d;
    logic [CNT_W-1:0]  bidx;
    logic              acc, abort_cell, rd_en, push, pop;
    logic [IDX_W-1:0]  rd_idx;
    route_t            tbl_rd, cfg_entry;
    logic              fifo_empty, fifo_full;
    logic [BYTE_W:0]   fifo_out;

    assign cfg_entry = '{ok: cfg_ok, link: cfg_link, vpi: cfg_vpi, vci: cfg_vci};

    atm_hp_route_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_entry (tbl_rd),
        .we       (cfg_we),
        .wr_idx   (cfg_addr),
        .wr_entry (cfg_entry)
    );

    atm_hp_fifo #(.WIDTH(BYTE_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (abort_cell),
        .push  (push),
        .din   ({bidx == CNT_W'(CELL_BYTES-1), in_data}),
        .pop   (pop),
        .dout  (fifo_out),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        s_d        = s_q;
        s_d.hv     = 1'b0;
        s_d.err    = 1'b0;
        bidx       = in_sop ? '0 : s_q.cnt;
        acc        = in_valid && (in_sop || s_q.cnt != '0);
        abort_cell = in_valid && in_sop && s_q.cnt != '0;
        rd_en      = acc && bidx == CNT_W'(LOOK_AT);
        // VCI so far: low nibble of byte 1, byte 2, high nibble of byte 3.
        rd_idx     = IDX_W'({s_q.hdr[11:0], in_data[7:4]});
        push       = acc && bidx > CNT_W'(HDR_BYTES);
        pop        = s_q.rel && !fifo_empty;

        if (acc) begin
            s_d.cnt = (bidx == CNT_W'(CELL_BYTES-1)) ? '0 : bidx + 1'b1;
            if (bidx < CNT_W'(HDR_BYTES)) begin
                s_d.hdr = in_sop ? HDR_BITS'(in_data)
                                 : {s_q.hdr[HDR_BITS-BYTE_W-1:0], in_data};
            end
            if (bidx == CNT_W'(HDR_BYTES)) begin
                s_d.hv   = 1'b1;
                s_d.word = {s_q.hdr, in_data};
                s_d.rt   = tbl_rd;
            end
        end

        if (s_d.hv) begin
            s_d.hold = HOLD_W'(HOLD_CYC);
        end else if (s_q.hold != '0) begin
            s_d.hold = s_q.hold - 1'b1;
        end
        if (pop && fifo_out[BYTE_W]) begin
            s_d.rel = 1'b0;
        end
        if (s_q.hold == HOLD_W'(1)) begin
            s_d.rel = 1'b1;
        end

        if (abort_cell) begin
            s_d.rel  = 1'b0;
            s_d.hold = '0;
            s_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hdr_valid = s_q.hv;
    assign hdr_word  = s_q.word;
    assign hdr_vpi   = s_q.word[43:36];
    assign hdr_vci   = s_q.word[35:20];
    assign hdr_pt    = s_q.word[19:17];
    assign hdr_clp   = s_q.word[16];
    assign hdr_hec   = s_q.word[15:8];
    assign rt_vpi    = s_q.rt.vpi;
    assign rt_vci    = s_q.rt.vci;
    assign rt_link   = s_q.rt.link;
    assign rt_drop   = !s_q.rt.ok;
    assign pay_valid = pop;
    assign pay_data  = fifo_out[BYTE_W-1:0];
    assign pay_last  = pop && fifo_out[BYTE_W];
    assign cell_err  = s_q.err;

    assert_one_hdr_per_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> !hdr_valid);
    assert_abort_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cell_err |-> (fifo_empty && !pay_valid));
    assert_last_ends_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_last && s_q.hold != HOLD_W'(1)) |=> !pay_valid);
endmodule

// File: tb/atm_hdr_proc_tb.sv
module atm_hdr_proc_tb;
    localparam int HOLD = 6;
    localparam int NV   = 5;
    localparam logic [47:0] VEC [NV] = '{
        48'h0120_0340_5AC3,
        48'hAFF1_278B_117E,
        48'h380F_FAB4_E001,
        48'h0070_155F_00FF,
        48'h544B_E342_9942
    };
    localparam bit VGAP [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sop = 0;
    logic [7:0] in_data = 0;
    logic cfg_we = 0, cfg_ok = 0;
    logic [7:0] cfg_addr = 0, cfg_vpi = 0;
    logic [1:0] cfg_link = 0;
    logic [15:0] cfg_vci = 0;
    logic hdr_valid, hdr_clp, rt_drop, pay_valid, pay_last, cell_err;
    logic [47:0] hdr_word;
    logic [7:0] hdr_vpi, hdr_hec, rt_vpi, pay_data;
    logic [15:0] hdr_vci, rt_vci;
    logic [2:0] hdr_pt;
    logic [1:0] rt_link;

    atm_hdr_proc u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_ok(cfg_ok), .cfg_link(cfg_link),
        .cfg_vpi(cfg_vpi), .cfg_vci(cfg_vci), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
        .hdr_vpi(hdr_vpi), .hdr_vci(hdr_vci), .hdr_pt(hdr_pt), .hdr_clp(hdr_clp),
        .hdr_hec(hdr_hec), .rt_vpi(rt_vpi), .rt_vci(rt_vci), .rt_link(rt_link),
        .rt_drop(rt_drop), .pay_valid(pay_valid), .pay_data(pay_data),
        .pay_last(pay_last), .cell_err(cell_err)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model of the table
    bit          m_ok   [256];
    logic [1:0]  m_link [256];
    logic [7:0]  m_vpi  [256];
    logic [15:0] m_vci  [256];

    // Monitor state
    int cyc = 0, hv_cnt = 0, hv_cyc = 0, first_pay = -1, pcnt = 0, bad_pay = 0;
    int last_idx = -1, pidx = 6, err_cnt = 0;
    logic [47:0] c_word;
    logic [7:0] c_vpi, c_hec, c_rvpi, tag;
    logic [15:0] c_vci, c_rvci;
    logic [2:0] c_pt;
    logic [1:0] c_link;
    logic c_clp, c_drop;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (cell_err) err_cnt <= err_cnt + 1;
            if (hdr_valid) begin
                hv_cnt <= hv_cnt + 1; hv_cyc <= cyc;
                c_word <= hdr_word; c_vpi <= hdr_vpi; c_vci <= hdr_vci; c_pt <= hdr_pt;
                c_clp <= hdr_clp; c_hec <= hdr_hec; c_rvpi <= rt_vpi; c_rvci <= rt_vci;
                c_link <= rt_link; c_drop <= rt_drop; tag <= hdr_word[7:0];
                pidx <= 6; pcnt <= 0; first_pay <= -1; last_idx <= -1; bad_pay <= 0;
            end else if (pay_valid) begin
                if (first_pay < 0) first_pay <= cyc;
                if (pay_data != (8'(pidx) ^ tag)) bad_pay <= bad_pay + 1;
                if (pay_last) last_idx <= pidx;
                pidx <= pidx + 1; pcnt <= pcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] cell_byte(input logic [47:0] w, input int i);
        if (i < 6) return w[47-8*i -: 8];
        return 8'(i) ^ w[7:0];
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] a, input bit ok, input logic [1:0] l,
                             input logic [7:0] vp, input logic [15:0] vc);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_ok = ok; cfg_link = l; cfg_vpi = vp; cfg_vci = vc;
        @(negedge clk);
        cfg_we = 0;
        m_ok[a] = ok; m_link[a] = l; m_vpi[a] = vp; m_vci[a] = vc;
    endtask

    // Send nb bytes of a cell; optionally write the table on the byte-3 cycle.
    task automatic send_cell(input logic [47:0] w, input int nb, input bit gaps,
                             input bit wr3, input logic [1:0] nl,
                             input logic [7:0] nvp, input logic [15:0] nvc);
        for (int i = 0; i < nb; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk); in_valid = 0; in_sop = 0; cfg_we = 0;
            end
            @(negedge clk);
            in_valid = 1; in_sop = (i == 0); in_data = cell_byte(w, i);
            if (wr3 && i == 3) begin
                cfg_we = 1; cfg_addr = w[27:20]; cfg_ok = 1;
                cfg_link = nl; cfg_vpi = nvp; cfg_vci = nvc;
            end else begin
                cfg_we = 0;
            end
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; cfg_we = 0;
    endtask

    task automatic check_cell(input logic [47:0] w, input bit gap, input int hv_before);
        logic [7:0] ix;
        ix = w[27:20];
        chk(hv_cnt == hv_before + 1, "R2", "header pulses", 64'(hv_cnt), 64'(hv_before + 1));
        chk(c_word == w, "R2", "hdr_word", c_word, w);
        chk({c_vpi, c_vci, c_pt, c_clp, c_hec} == {w[43:36], w[35:20], w[19:17], w[16], w[15:8]},
            "R1", "fields", {c_vpi, c_vci, c_pt, c_clp, c_hec}, w[43:8]);
        chk(c_drop == !m_ok[ix], "R4", "rt_drop", 64'(c_drop), 64'(!m_ok[ix]));
        if (m_ok[ix])
            chk({c_link, c_rvpi, c_rvci} == {m_link[ix], m_vpi[ix], m_vci[ix]}, "R3", "route",
                {c_link, c_rvpi, c_rvci}, {m_link[ix], m_vpi[ix], m_vci[ix]});
        chk(pcnt == 47 && bad_pay == 0 && last_idx == 52, "R6", "payload cnt/bad/last",
            {16'(pcnt), 16'(bad_pay), 32'(last_idx)}, {16'd47, 16'd0, 32'd52});
        if (!gap)
            chk(first_pay - hv_cyc == HOLD, "R6", "hold delay", 64'(first_pay - hv_cyc), 64'(HOLD));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hb, eb;
        for (int i = 0; i < 256; i++) m_ok[i] = 0;
        idle(3);
        chk(!hdr_valid && !pay_valid && !cell_err, "R9", "outputs in reset",
            {hdr_valid, pay_valid, cell_err}, 0);
        rst_n = 1;
        idle(2);
        chk(!hdr_valid && !pay_valid && !cell_err, "R9", "outputs after reset",
            {hdr_valid, pay_valid, cell_err}, 0);

        cfg_write(8'h34, 1, 2'd1, 8'h21, 16'h0A01);
        cfg_write(8'h78, 1, 2'd3, 8'h9C, 16'hBEEF);
        cfg_write(8'hAB, 1, 2'd2, 8'h00, 16'hFFFF);

        // R7: stray bytes with no start strobe are ignored
        hb = hv_cnt;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); in_valid = 1; in_sop = 0; in_data = 8'(i + 1);
        end
        @(negedge clk); in_valid = 0;
        idle(15);
        chk(hv_cnt == hb && err_cnt == 0 && !pay_valid, "R7", "stray bytes ignored",
            {32'(hv_cnt), 32'(err_cnt)}, {32'(hb), 32'd0});

        // Vector table walk (R1..R4, R6; gapped entries exercise R7 stalls)
        for (int k = 0; k < NV; k++) begin
            hb = hv_cnt;
            send_cell(VEC[k], 53, VGAP[k], 0, 0, 0, 0);
            idle(20);
            check_cell(VEC[k], VGAP[k], hb);
        end

        // R5: write to the same entry on the lookup edge -> old contents
        hb = hv_cnt;
        send_cell(VEC[0], 53, 0, 1, 2'd0, 8'h66, 16'h1234);
        idle(20);
        check_cell(VEC[0], 0, hb);
        m_ok[8'h34] = 1; m_link[8'h34] = 0; m_vpi[8'h34] = 8'h66; m_vci[8'h34] = 16'h1234;
        hb = hv_cnt;
        send_cell(VEC[4], 53, 0, 0, 0, 0, 0);
        idle(20);
        check_cell(VEC[4], 0, hb);
        chk(c_rvpi == 8'h66, "R5", "new entry on next cell", 64'(c_rvpi), 64'h66);

        // R8: new start mid-cell while payload is still held
        eb = err_cnt;
        send_cell(VEC[1], 9, 0, 0, 0, 0, 0);
        hb = hv_cnt;
        send_cell(VEC[2], 53, 0, 0, 0, 0, 0);
        idle(20);
        chk(err_cnt == eb + 1, "R8", "error pulse", 64'(err_cnt), 64'(eb + 1));
        check_cell(VEC[2], 0, hb);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule